// File: doc/BRIEF.md
# Paged Serial Flash Continuous Read Front End

This block is the device-side command decoder and read datapath of a serial flash whose main array is organised as 4096 pages of 528 bytes. A host selects the device by pulling the active-low select low, then clocks in an 8-bit command and a 24-bit address on the serial input, most significant bit first. After a run of don't-care clocks the block streams array bytes on its serial output for as long as the host keeps clocking, with no further address or control input.

The byte-within-page counter is not a power-of-two counter: it rolls from 527 back to 0 and carries into a separate 12-bit page counter, so a read crosses page boundaries and wraps from the last page to the first. Two read commands pick the output timing category. One changes the output on falling serial-clock edges, for hosts that sample on rising edges (clock modes 0 and 3). The other changes it on rising edges, for hosts that sample on falling edges (idle-low or idle-high clock). The serial inputs are sampled on a faster system clock, and the array contents are a fixed arithmetic function of the address, so the read path can be checked without a stored image.

Top module: `paged_flash_reader`

## Requirements
- R1: `soEn` is 0 after reset. It is 0 from the second clock after `csN` is seen high, and it stays 0 while `csN` remains high.
- R2: A command starts only on a falling edge of `csN`. Bits are taken from `si` on rising `sck` edges, most significant bit first: 8 opcode bits, then 24 address bits laid out as 2 ignored bits, a 12-bit page and a 10-bit byte.
- R3: Opcode 0xA5 selects the falling-edge category. Bit j of the stream (counted from 0) is driven at the falling `sck` edge after rising edge 32+D+j, and `soData` holds still while `sck` stays high.
- R4: Opcode 0xC3 selects the rising-edge category. Bit j of the stream is driven at rising `sck` edge 33+D+j, and `soData` holds still while `sck` stays low.
- R5: D is the don't-care clock count between the address and the data: `DUMMY_EDGE` for 0xA5 and `DUMMY_POL` for 0xC3, both 32 by default. `soEn` stays 0 through dummy clock D-1 and is 1 after dummy clock D.
- R6: The array byte at page p and byte b is ((p mod 256) + 3*(b mod 256)) mod 256, XOR an 8-bit value made of p[11:8] in bits 7:4, two zero bits, and b[9:8] in bits 1:0. Each byte is sent MSB first.
- R7: The first byte streamed is the one at the start address. Each further byte comes from the next address, with no new address input.
- R8: When the byte counter is at 527 or above, it moves to 0 and the page counter increments. A start byte above 527 is read once, and then the read continues at byte 0 of the next page.
- R9: After page 4095 the page counter wraps to page 0.
- R10: After an opcode other than 0xA5 or 0xC3, `soEn` stays 0 for the rest of that selection. The next selection decodes normally.
- R11: Raising `csN` at any point aborts the command and clears the bit count, so the next selection decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial command and address input |
| soData | output | 1 | Serial read data |
| soEn | output | 1 | Output drive enable; 0 means the pin floats |

## Verification
The assertions take for granted that `csN`, `sck` and `si` come from the same clock domain as `clk`, and that each `sck` level lasts at least one `clk` cycle. Under those conditions every `sck` edge is seen exactly once. They also assume that `csN` falls at least one cycle before the first rising `sck` edge. The stimulus meets these conditions by changing every input on the falling edge of `clk`, by holding each `sck` level for two cycles, and by waiting two cycles after selecting before it clocks the first bit. The hold checks on `soData` depend on the same rule, since they compare its value across two cycles in which `sck` has not changed.

// File: rtl/paged_read_pkg.sv
package paged_read_pkg;

  localparam logic [7:0] OPC_RD_EDGE = 8'hA5;
  localparam logic [7:0] OPC_RD_POL  = 8'hC3;

  typedef enum logic [2:0] {
    ST_LOCK,
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA
  } rdState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic loadByte;
    logic shiftOut;
  } dpStrobe_t;

endpackage

// File: rtl/paged_read_ctl.sv
module paged_read_ctl
  import paged_read_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_EDGE = 32,
  parameter int DUMMY_POL  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic [7:0] opcodeNext,
  output dpStrobe_t  strobe,
  output logic       soEn,
  output logic       catPol
);

  localparam int MAX_AD  = (ADDR_BITS > DUMMY_EDGE) ? ADDR_BITS : DUMMY_EDGE;
  localparam int MAXC    = (MAX_AD > DUMMY_POL) ? MAX_AD : DUMMY_POL;
  localparam int CNT_W   = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'((DUMMY_EDGE > 0) ? DUMMY_EDGE - 1 : 0);
  localparam logic [CNT_W-1:0] POL_LAST  = CNT_W'((DUMMY_POL > 0) ? DUMMY_POL - 1 : 0);
  localparam logic EDGE_NONE = (DUMMY_EDGE == 0);
  localparam logic POL_NONE  = (DUMMY_POL == 0);

  rdState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic             sckQ;
  logic             sckRise;
  logic             sckFall;
  logic             outEdge;
  logic             dummyNone;
  logic [CNT_W-1:0] dummyLast;

  always_comb begin
    sckRise   = sck & ~sckQ;
    sckFall   = ~sck & sckQ;
    outEdge   = catPol ? sckRise : sckFall;
    dummyLast = catPol ? POL_LAST : EDGE_LAST;
    dummyNone = catPol ? POL_NONE : EDGE_NONE;
    strobe    = '0;
    if (!csN) begin
      strobe.shiftIn  = sckRise && (state == ST_OPC || state == ST_ADDR);
      strobe.loadAddr = sckRise && (state == ST_ADDR) && (cnt == ADDR_LAST);
      strobe.loadByte = outEdge && (state == ST_DATA) && (bitIdx == 3'd0);
      strobe.shiftOut = outEdge && (state == ST_DATA) && (bitIdx != 3'd0);
    end
  end

  assign soEn = (state == ST_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_LOCK;
      cnt    <= '0;
      bitIdx <= '0;
      sckQ   <= 1'b0;
      catPol <= 1'b0;
    end else begin
      sckQ <= sck;
      if (csN) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        bitIdx <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            state <= ST_OPC;
            cnt   <= '0;
          end
          ST_OPC: if (sckRise) begin
            if (cnt == OPC_LAST) begin
              cnt <= '0;
              if (opcodeNext == OPC_RD_EDGE) begin
                catPol <= 1'b0;
                state  <= ST_ADDR;
              end else if (opcodeNext == OPC_RD_POL) begin
                catPol <= 1'b1;
                state  <= ST_ADDR;
              end else begin
                state <= ST_LOCK;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: if (sckRise) begin
            if (cnt == ADDR_LAST) begin
              cnt    <= '0;
              bitIdx <= '0;
              state  <= dummyNone ? ST_DATA : ST_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DUMMY: if (sckRise) begin
            if (cnt == dummyLast) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: if (outEdge) bitIdx <= bitIdx + 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/paged_read_dp.sv
module paged_read_dp
  import paged_read_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 10,
  parameter int PAGE_BYTES = 528
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              si,
  input  dpStrobe_t         strobe,
  output logic [7:0]        opcodeNext,
  output logic              soData,
  output logic [PAGE_W-1:0] pageCnt,
  output logic [BYTE_W-1:0] byteCnt
);

  localparam int FIELD_W = PAGE_W + BYTE_W;
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(PAGE_BYTES - 1);

  logic [FIELD_W-2:0] shiftReg;
  logic [FIELD_W-1:0] shiftNext;
  logic [7:0]         outShift;
  logic [7:0]         memByte;

  always_comb begin
    shiftNext  = {shiftReg, si};
    opcodeNext = shiftNext[7:0];
    memByte    = (pageCnt[7:0] + byteCnt[7:0] + {byteCnt[6:0], 1'b0})
               ^ {pageCnt[11:8], 2'b00, byteCnt[9:8]};
  end

  assign soData = outShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      pageCnt  <= '0;
      byteCnt  <= '0;
      outShift <= '0;
    end else begin
      if (strobe.shiftIn) shiftReg <= shiftNext[FIELD_W-2:0];
      if (strobe.loadAddr) begin
        {pageCnt, byteCnt} <= shiftNext;
      end else if (strobe.loadByte) begin
        outShift <= memByte;
        if (byteCnt >= BYTE_LAST) begin
          byteCnt <= '0;
          pageCnt <= pageCnt + 1'b1;
        end else begin
          byteCnt <= byteCnt + 1'b1;
        end
      end else if (strobe.shiftOut) begin
        outShift <= {outShift[6:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/paged_flash_reader.sv
module paged_flash_reader
  import paged_read_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int PAGE_BYTES = 528,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_EDGE = 32,
  parameter int DUMMY_POL  = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic soData,
  output logic soEn
);

  localparam int BYTE_W = $clog2(PAGE_BYTES);

  dpStrobe_t         strobe;
  logic [7:0]        opcodeNext;
  logic              catPol;
  logic              byteLoad;
  logic [PAGE_W-1:0] pageCnt;
  logic [BYTE_W-1:0] byteCnt;

  assign byteLoad = strobe.loadByte;

  paged_read_ctl #(
    .ADDR_BITS (ADDR_BITS),
    .DUMMY_EDGE(DUMMY_EDGE),
    .DUMMY_POL (DUMMY_POL)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sck       (sck),
    .opcodeNext(opcodeNext),
    .strobe    (strobe),
    .soEn      (soEn),
    .catPol    (catPol)
  );

  paged_read_dp #(
    .PAGE_W    (PAGE_W),
    .BYTE_W    (BYTE_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .si        (si),
    .strobe    (strobe),
    .opcodeNext(opcodeNext),
    .soData    (soData),
    .pageCnt   (pageCnt),
    .byteCnt   (byteCnt)
  );

endmodule

// File: rtl/paged_flash_reader_chk.sv
module paged_flash_reader_chk #(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 10,
  parameter int PAGE_BYTES = 528
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              sck,
  input logic              soEn,
  input logic              soData,
  input logic              catPol,
  input logic              byteLoad,
  input logic [PAGE_W-1:0] pageCnt,
  input logic [BYTE_W-1:0] byteCnt
);

  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(PAGE_BYTES - 1);

  AST_SO_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !soEn); // R1

  AST_SO_ON_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soEn) |-> !csN); // R2

  AST_HOLD_EDGE_CAT: assert property (@(posedge clk) disable iff (!rstN)
    (!catPol && soEn && $past(soEn) && sck && $past(sck)) |-> $stable(soData)); // R3

  AST_HOLD_POL_CAT: assert property (@(posedge clk) disable iff (!rstN)
    (catPol && soEn && $past(soEn) && !sck && !$past(sck)) |-> $stable(soData)); // R4

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (byteLoad && byteCnt < BYTE_LAST) |=>
      (byteCnt == $past(byteCnt) + 1'b1) && $stable(pageCnt)); // R7

  AST_PAGE_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (byteLoad && byteCnt >= BYTE_LAST) |=>
      (byteCnt == '0) && (pageCnt == $past(pageCnt) + 1'b1)); // R8

endmodule

bind paged_flash_reader paged_flash_reader_chk #(
  .PAGE_W    (PAGE_W),
  .BYTE_W    (BYTE_W),
  .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sck     (sck),
  .soEn    (soEn),
  .soData  (soData),
  .catPol  (catPol),
  .byteLoad(byteLoad),
  .pageCnt (pageCnt),
  .byteCnt (byteCnt)
);

// File: tb/paged_flash_reader_bench.sv
module paged_flash_reader_bench;

  localparam int DUMMY = 32;
  localparam logic [7:0] OPC_EDGE = 8'hA5;
  localparam logic [7:0] OPC_POL  = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic soData;
  logic soEn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [7:0] got [0:7];
  logic enBeforeLast;
  logic enAfterLast;

  always #5 clk = ~clk;

  paged_flash_reader u_paged_flash_reader (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .soData(soData), .soEn(soEn)
  );

  function automatic logic [7:0] expByte(int p, int b);
    logic [11:0] pp;
    logic [9:0]  bb;
    int v;
    pp = 12'(p);
    bb = 10'(b);
    v = (int'(pp[7:0]) + 3 * int'(bb[7:0])) % 256;
    return 8'(v) ^ {pp[11:8], 2'b00, bb[9:8]};
  endfunction

  task automatic check(string req, logic [31:0] gotV, logic [31:0] expV);
    nChecks++;
    if (gotV !== expV) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, gotV, expV);
    end
  endtask

  task automatic pulse(input logic b, output logic lo, output logic hi);
    si = b;
    @(negedge clk); @(negedge clk);
    lo = soData;
    sck = 1'b1;
    @(negedge clk); @(negedge clk);
    hi = soData;
    sck = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    logic lo, hi;
    for (int i = n - 1; i >= 0; i--) pulse(v[i], lo, hi);
  endtask

  task automatic selectDev();
    csN = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic deselectDev();
    csN = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  // Full read: command, address, dummies, n bytes, then extra bits before deselect
  task automatic readCmd(input logic [7:0] opc, input int p, input int b,
                         input int n, input int extra);
    logic lo, hi;
    selectDev();
    sendBits(32'(opc), 8);
    sendBits({8'h00, 2'b11, 12'(p), 10'(b)}, 24);
    for (int i = 0; i < DUMMY - 1; i++) pulse(1'b1, lo, hi);
    enBeforeLast = soEn;
    pulse(1'b1, lo, hi);
    enAfterLast = soEn;
    for (int k = 0; k < n; k++) begin
      for (int bit_i = 7; bit_i >= 0; bit_i--) begin
        pulse(1'b0, lo, hi);
        got[k][bit_i] = (opc == OPC_POL) ? hi : lo;
      end
    end
    for (int i = 0; i < extra; i++) pulse(1'b0, lo, hi);
    deselectDev();
  endtask

  task automatic expectRead(string req, input logic [7:0] opc, input int p,
                            input int b, input int n);
    int ep, eb;
    readCmd(opc, p, b, n, 0);
    check({req, " R5 dummy gap"}, 32'(enBeforeLast), 32'd0);
    check({req, " R5 data enable"}, 32'(enAfterLast), 32'd1);
    check({req, " R1 float after deselect"}, 32'(soEn), 32'd0);
    ep = p;
    eb = b;
    for (int k = 0; k < n; k++) begin
      check(req, 32'(got[k]), 32'(expByte(ep, eb)));
      if (eb >= 527) begin
        eb = 0;
        ep = (ep + 1) % 4096;
      end else begin
        eb++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int starts [0:7];
    int pages  [0:3];
    logic lo, hi;
    logic sawEn;
    starts = '{0, 1, 127, 255, 256, 511, 512, 526};
    pages  = '{0, 1, 100, 2049};

    repeat (3) @(negedge clk);
    check("R1 reset", 32'(soEn), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'(soEn), 32'd0);

    // R2 R3 R4 R6 R7: sweep start addresses in both categories
    for (int m = 0; m < 2; m++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int si_i = 0; si_i < 8; si_i++) begin
          expectRead(m == 0 ? "R3 R6 R7 R2" : "R4 R6 R7 R2",
                     m == 0 ? OPC_EDGE : OPC_POL, pages[pi], starts[si_i], 2);
        end
      end
    end

    // R8: byte wrap with page carry, including start bytes above 527
    expectRead("R8 wrap edge", OPC_EDGE, 7, 526, 4);
    expectRead("R8 wrap pol", OPC_POL, 8, 527, 3);
    expectRead("R8 high start", OPC_EDGE, 3, 1000, 2);
    expectRead("R8 high start pol", OPC_POL, 300, 1023, 2);

    // R9: last page wraps to page 0
    expectRead("R9 page wrap edge", OPC_EDGE, 4095, 526, 3);
    expectRead("R9 page wrap pol", OPC_POL, 4095, 527, 2);

    // R10: unknown opcode keeps output off for the whole selection
    selectDev();
    sendBits(32'h5A, 8);
    sawEn = 1'b0;
    for (int i = 0; i < 24 + DUMMY + 16; i++) begin
      pulse(1'b1, lo, hi);
      sawEn = sawEn | soEn;
    end
    check("R10 ignored opcode", 32'(sawEn), 32'd0);
    deselectDev();
    expectRead("R10 next selection", OPC_POL, 12, 40, 2);

    // R11: abort mid-address, then a fresh command decodes from bit 0
    selectDev();
    sendBits(32'(OPC_EDGE), 8);
    sendBits(32'h3FF, 10);
    deselectDev();
    check("R11 abort float", 32'(soEn), 32'd0);
    expectRead("R11 after abort", OPC_EDGE, 77, 300, 2);

    // R11 R1: abort mid-data
    readCmd(OPC_EDGE, 20, 10, 1, 3);
    check("R11 abort mid-data byte", 32'(got[0]), 32'(expByte(20, 10)));
    check("R1 abort mid-data float", 32'(soEn), 32'd0);
    expectRead("R11 after data abort", OPC_POL, 21, 11, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule